// File: doc/BRIEF.md
# Prefix-Aware Instruction Length Framer

This block sits behind an instruction byte source for an 8-bit processor and splits the incoming stream into whole instructions. One byte arrives per clock, qualified by a valid strobe. The framer first checks whether the leading byte is one of three opcode-page selectors. It then classifies the opcode on the selected page and counts off the operand bytes that follow. The block does not execute instructions or read memory. It only frames them.

For every instruction the framer pulses a start flag after the first byte is taken. After the last byte it pulses an end flag. That end pulse carries the total byte count, the addressing-mode code and the page code. An opcode that is not defined on its page ends the instruction at once with an illegal flag set. The byte after it is then treated as the start of a new instruction.

Top module: `ilen_decoder`

## Requirements
- R1: With `rst` high at a clock edge, `sop_o`, `eoi_o` and `illegal_o` are 0 after that edge. The first valid byte after `rst` falls is decoded as the first byte of an instruction, whatever was in progress before the reset.
- R2: A cycle with `byte_valid` low changes nothing. No start or end pulse follows it, and the operand count does not advance, even when `byte_in` holds a page-selector value.
- R3: `sop_o` is high for exactly one cycle, the cycle after the first byte of each instruction is accepted. That first byte may be a page selector. `sop_o` is low after every other byte.
- R4: A first byte of 0x18, 0x1A or 0xCD selects page code 1, 2 or 3 respectively, and adds one byte to the reported length. Any other first byte is the opcode itself, with page code 0.
- R5: On page 0 the length is 1 for inherent opcodes, 2 for relative, direct, indexed and 8-bit immediate opcodes, and 3 for extended opcodes.
- R6: Opcodes 0x83, 0x8C, 0x8E, 0xC3, 0xCC and 0xCE carry a two-byte immediate, so they report length 3 on page 0. Page 1 with 0x8C or 0xCE, and page 2 with 0x83, report length 4.
- R7: Bit set and clear opcodes 0x14, 0x15, 0x1C and 0x1D take two operand bytes (mode 6). Bit-test branch opcodes 0x12, 0x13, 0x1E and 0x1F take three (mode 7). Page 1 accepts only the 0x1C to 0x1F forms, each one byte longer.
- R8: `mode_o` codes are: 0 inherent, 1 immediate, 2 direct, 3 extended, 4 indexed, 5 relative, 6 bit set/clear, 7 bit-test branch.
- R9: `eoi_o` is high for one cycle, the cycle after the last byte of an instruction is accepted. `len_o`, `mode_o` and `page_o` describe that instruction in the same cycle.
- R10: An opcode undefined on its page gives `eoi_o` and `illegal_o` together. In that case `len_o` is the number of bytes consumed (1, or 2 with a page selector) and `mode_o` is 0. The next valid byte starts a new instruction.
- R11: Page 2 defines only opcodes 0x83, 0x93, 0xB3, 0xA3, 0xAC, 0xEE and 0xEF. Page 3 defines only 0xA3, 0xAC, 0xEE and 0xEF, all of them indexed. Page 1 defines the indexed rows 0x6x, 0xAx and 0xEx, plus a small set of register-Y opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Qualifies `byte_in` in this cycle |
| byte_in | input | 8 | Instruction stream byte |
| sop_o | output | 1 | First byte of an instruction was accepted |
| eoi_o | output | 1 | Last byte of an instruction was accepted |
| len_o | output | 3 | Total instruction length in bytes, valid with `eoi_o` |
| mode_o | output | 3 | Addressing-mode code, valid with `eoi_o` |
| page_o | output | 2 | Page code 0..3, valid with `eoi_o` |
| illegal_o | output | 1 | Opcode undefined on its page, valid with `eoi_o` |

## Verification
Every output is registered on the edge that accepts its byte. The start pulse is therefore due one cycle after the first byte, and the end pulse with its length, mode and page one cycle after the last byte. The bench drives each byte on the falling edge and samples 2 ns after the rising edge that accepted it. That sample falls in the one cycle where each pulse must be visible. The same timing applies inside idle gaps: the bench samples after each strobe-low edge and confirms that no pulse appeared.

// File: rtl/ilen_pkg.sv
package ilen_pkg;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = 2;

  localparam logic [DATA_W-1:0] SEL_P1 = 8'h18;
  localparam logic [DATA_W-1:0] SEL_P2 = 8'h1A;
  localparam logic [DATA_W-1:0] SEL_P3 = 8'hCD;

  typedef enum logic [1:0] {PG_MAIN, PG_ONE, PG_TWO, PG_THREE} page_e;

  typedef enum logic [2:0] {
    M_INH, M_IMM, M_DIR, M_EXT, M_IDX, M_REL, M_BSC, M_BBR
  } amode_e;

  typedef struct packed {
    logic             ok;
    amode_e           mode;
    logic [CNT_W-1:0] nopnd;
  } opinfo_t;
endpackage

// File: rtl/ilen_classify.sv
module ilen_classify
  import ilen_pkg::*;
(
  input  page_e             page,
  input  logic [DATA_W-1:0] opc,
  output opinfo_t           info
);
  logic [3:0] hi, lo;
  logic       set_a;   // defined columns of rows 0x4/0x5
  logic       set_b;   // defined columns of rows 0x6/0x7

  assign hi = opc[7:4];
  assign lo = opc[3:0];

  always_comb begin
    unique case (lo)
      4'h1, 4'h2, 4'h5, 4'hB, 4'hE: set_a = 1'b0;
      default:                      set_a = 1'b1;
    endcase
    set_b = set_a | (lo == 4'hE);
  end

  function automatic opinfo_t mk(input amode_e m, input logic [CNT_W-1:0] n);
    opinfo_t r;
    r.ok = 1'b1; r.mode = m; r.nopnd = n;
    return r;
  endfunction

  always_comb begin
    info = '{ok: 1'b0, mode: M_INH, nopnd: '0};
    unique case (page)
      PG_MAIN: begin
        case (hi)
          4'h0, 4'h3: info = mk(M_INH, 2'd0);
          4'h1: begin
            case (lo)
              4'h0, 4'h1, 4'h6, 4'h7, 4'h9, 4'hB: info = mk(M_INH, 2'd0);
              4'h2, 4'h3, 4'hE, 4'hF:             info = mk(M_BBR, 2'd3);
              4'h4, 4'h5, 4'hC, 4'hD:             info = mk(M_BSC, 2'd2);
              default: ;
            endcase
          end
          4'h2:       info = mk(M_REL, 2'd1);
          4'h4, 4'h5: if (set_a) info = mk(M_INH, 2'd0);
          4'h6:       if (set_b) info = mk(M_IDX, 2'd1);
          4'h7:       if (set_b) info = mk(M_EXT, 2'd2);
          4'h8, 4'hC: begin
            case (lo)
              4'h7:             ;
              4'hD:             if (hi == 4'h8) info = mk(M_REL, 2'd1);
              4'hF:             info = mk(M_INH, 2'd0);
              4'h3, 4'hC, 4'hE: info = mk(M_IMM, 2'd2);
              default:          info = mk(M_IMM, 2'd1);
            endcase
          end
          4'h9, 4'hD: info = mk(M_DIR, 2'd1);
          4'hA, 4'hE: info = mk(M_IDX, 2'd1);
          default:    info = mk(M_EXT, 2'd2);
        endcase
      end
      PG_ONE: begin
        case (opc)
          8'h08, 8'h09, 8'h30, 8'h35, 8'h38, 8'h3A, 8'h3C, 8'h8F:
                              info = mk(M_INH, 2'd0);
          8'h8C, 8'hCE:       info = mk(M_IMM, 2'd2);
          8'h9C, 8'hDE, 8'hDF: info = mk(M_DIR, 2'd1);
          8'hBC, 8'hFE, 8'hFF: info = mk(M_EXT, 2'd2);
          8'h1C, 8'h1D:       info = mk(M_BSC, 2'd2);
          8'h1E, 8'h1F:       info = mk(M_BBR, 2'd3);
          default: begin
            if ((hi == 4'h6 && set_b) || hi == 4'hA || hi == 4'hE)
              info = mk(M_IDX, 2'd1);
          end
        endcase
      end
      PG_TWO: begin
        case (opc)
          8'h83:                      info = mk(M_IMM, 2'd2);
          8'h93:                      info = mk(M_DIR, 2'd1);
          8'hB3:                      info = mk(M_EXT, 2'd2);
          8'hA3, 8'hAC, 8'hEE, 8'hEF: info = mk(M_IDX, 2'd1);
          default: ;
        endcase
      end
      default: begin
        case (opc)
          8'hA3, 8'hAC, 8'hEE, 8'hEF: info = mk(M_IDX, 2'd1);
          default: ;
        endcase
      end
    endcase
  end

  // R11
  always_comb begin
    if (page == PG_THREE && info.ok)
      r11_page3_idx_chk: assert (info.mode == M_IDX);
  end
endmodule

// File: rtl/ilen_framer.sv
module ilen_framer
  import ilen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  input  opinfo_t           info,
  output page_e             page_sel,
  output logic              sop_o,
  output logic              eoi_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [2:0]        mode_o,
  output logic [1:0]        page_o,
  output logic              illegal_o
);
  typedef enum logic [1:0] {S_FIRST, S_OPC, S_OPND} st_e;

  st_e              st_q;
  page_e            page_q;
  logic [CNT_W-1:0] rem_q;
  logic [LEN_W-1:0] plen_q;
  amode_e           pmode_q;

  logic             is_sel;
  page_e            sel_code;
  logic [LEN_W-1:0] hdr_len;

  always_comb begin
    is_sel   = 1'b1;
    sel_code = PG_MAIN;
    case (byte_in)
      SEL_P1:  sel_code = PG_ONE;
      SEL_P2:  sel_code = PG_TWO;
      SEL_P3:  sel_code = PG_THREE;
      default: is_sel   = 1'b0;
    endcase
  end

  assign page_sel = (st_q == S_OPC) ? page_q : PG_MAIN;
  assign hdr_len  = (page_sel == PG_MAIN) ? LEN_W'(1) : LEN_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_FIRST;
      page_q    <= PG_MAIN;
      rem_q     <= '0;
      plen_q    <= '0;
      pmode_q   <= M_INH;
      sop_o     <= 1'b0;
      eoi_o     <= 1'b0;
      illegal_o <= 1'b0;
      len_o     <= '0;
      mode_o    <= '0;
      page_o    <= '0;
    end else begin
      sop_o     <= 1'b0;
      eoi_o     <= 1'b0;
      illegal_o <= 1'b0;
      if (byte_valid) begin
        if (st_q == S_OPND) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            eoi_o  <= 1'b1;
            len_o  <= plen_q;
            mode_o <= pmode_q;
            page_o <= page_q;
            st_q   <= S_FIRST;
          end
        end else if (st_q == S_FIRST && is_sel) begin
          sop_o  <= 1'b1;
          page_q <= sel_code;
          st_q   <= S_OPC;
        end else begin
          if (st_q == S_FIRST) begin
            sop_o  <= 1'b1;
            page_q <= PG_MAIN;
          end
          if (!info.ok || info.nopnd == '0) begin
            eoi_o     <= 1'b1;
            illegal_o <= !info.ok;
            len_o     <= hdr_len;
            mode_o    <= info.ok ? info.mode : M_INH;
            page_o    <= page_sel;
            st_q      <= S_FIRST;
          end else begin
            rem_q   <= info.nopnd;
            plen_q  <= hdr_len + LEN_W'(info.nopnd);
            pmode_q <= info.mode;
            st_q    <= S_OPND;
          end
        end
      end
    end
  end

  // R10
  illegal_ends_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> eoi_o);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> (!sop_o && !eoi_o));
  // R3
  sop_only_first_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && st_q != S_FIRST) |=> !sop_o);
  // R4
  sel_adds_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_o && !illegal_o && page_o != 2'd0) |-> len_o >= LEN_W'(2));
  // R5
  inh_len_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_o && !illegal_o && mode_o == M_INH) |->
      len_o == ((page_o == 2'd0) ? LEN_W'(1) : LEN_W'(2)));
  // R7
  bbr_len_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_o && mode_o == M_BBR) |->
      len_o == ((page_o == 2'd0) ? LEN_W'(4) : LEN_W'(5)));
endmodule

// File: rtl/ilen_decoder.sv
module ilen_decoder
  import ilen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  output logic              sop_o,
  output logic              eoi_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [2:0]        mode_o,
  output logic [1:0]        page_o,
  output logic              illegal_o
);
  page_e   page_sel;
  opinfo_t info;

  ilen_classify u_cls (
    .page (page_sel),
    .opc  (byte_in),
    .info (info)
  );

  ilen_framer u_frm (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .info       (info),
    .page_sel   (page_sel),
    .sop_o      (sop_o),
    .eoi_o      (eoi_o),
    .len_o      (len_o),
    .mode_o     (mode_o),
    .page_o     (page_o),
    .illegal_o  (illegal_o)
  );
endmodule

// File: tb/tb_ilen_decoder.sv
`timescale 1ns/1ps
module tb_ilen_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       sop_o, eoi_o, illegal_o;
  logic [2:0] len_o, mode_o;
  logic [1:0] page_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ilen_decoder dut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
    .sop_o(sop_o), .eoi_o(eoi_o), .len_o(len_o), .mode_o(mode_o),
    .page_o(page_o), .illegal_o(illegal_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Feeds n bytes (first byte in seq[39:32]) with gap idle cycles between them.
  task automatic send(input int n, input logic [39:0] seq, input int gap,
                      input int xlen, input int xmode, input int xpage,
                      input int xill, input string tag);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); byte_valid = 1'b0; byte_in = 8'h18;
          @(posedge clk); #2;
          check("R2", "sop in gap", sop_o, 0);
          check("R2", "eoi in gap", eoi_o, 0);
        end
      end
      @(negedge clk); byte_valid = 1'b1; byte_in = seq[39-8*i -: 8];
      @(posedge clk); #2;
      check("R3", {tag, " sop"}, sop_o, (i == 0) ? 1 : 0);
      if (i == n - 1) begin
        check("R9", {tag, " eoi"}, eoi_o, 1);
        check(tag, "len", len_o, xlen);
        check("R8", {tag, " mode"}, mode_o, xmode);
        check("R4", {tag, " page"}, page_o, xpage);
        check("R10", {tag, " illegal"}, illegal_o, xill);
      end else begin
        check("R9", {tag, " early eoi"}, eoi_o, 0);
      end
    end
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check("R1", "sop after reset", sop_o, 0);
    check("R1", "eoi after reset", eoi_o, 0);
    check("R1", "illegal after reset", illegal_o, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_plain();
    send(1, 40'h01_00000000, 0, 1, 0, 0, 0, "R5");
    send(2, 40'h86_55000000, 0, 2, 1, 0, 0, "R5");
    send(2, 40'h96_10000000, 0, 2, 2, 0, 0, "R5");
    send(3, 40'hB6_12340000, 0, 3, 3, 0, 0, "R5");
    send(2, 40'hA6_05000000, 0, 2, 4, 0, 0, "R5");
    send(2, 40'h26_FE000000, 0, 2, 5, 0, 0, "R5");
  endtask

  task automatic t_imm16();
    send(3, 40'hCC_12340000, 0, 3, 1, 0, 0, "R6");
    send(3, 40'h8E_00FF0000, 0, 3, 1, 0, 0, "R6");
    send(4, 40'h18_CE000100, 0, 4, 1, 1, 0, "R6");
    send(4, 40'h1A_83000200, 0, 4, 1, 2, 0, "R6");
  endtask

  task automatic t_bits();
    send(3, 40'h14_200F0000, 0, 3, 6, 0, 0, "R7");
    send(3, 40'h1D_05800000, 0, 3, 6, 0, 0, "R7");
    send(4, 40'h12_20010400, 0, 4, 7, 0, 0, "R7");
    send(5, 40'h18_1E034010, 0, 5, 7, 1, 0, "R7");
  endtask

  task automatic t_pages();
    send(3, 40'h18_AB070000, 0, 3, 4, 1, 0, "R4");
    send(2, 40'h18_08000000, 0, 2, 0, 1, 0, "R11");
    send(3, 40'h1A_EE040000, 0, 3, 4, 2, 0, "R11");
    send(4, 40'h1A_B3123400, 0, 4, 3, 2, 0, "R11");
    send(3, 40'hCD_EF020000, 0, 3, 4, 3, 0, "R11");
  endtask

  task automatic t_illegal();
    send(1, 40'h41_00000000, 0, 1, 0, 0, 1, "R10");
    send(1, 40'h01_00000000, 0, 1, 0, 0, 0, "R10");
    send(2, 40'h1A_AB000000, 0, 2, 0, 2, 1, "R11");
    send(2, 40'h86_01000000, 0, 2, 1, 0, 0, "R10");
    send(2, 40'hCD_83000000, 0, 2, 0, 3, 1, "R11");
    send(2, 40'h18_18000000, 0, 2, 0, 1, 1, "R10");
    send(1, 40'hC7_00000000, 0, 1, 0, 0, 1, "R10");
  endtask

  task automatic t_gaps();
    send(3, 40'h18_AB070000, 3, 3, 4, 1, 0, "R2");
    send(3, 40'hF6_12340000, 2, 3, 3, 0, 0, "R2");
  endtask

  task automatic t_reset_mid();
    @(negedge clk); byte_valid = 1'b1; byte_in = 8'hB6;
    @(negedge clk); byte_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #2;
    check("R1", "eoi during reset", eoi_o, 0);
    @(negedge clk); rst = 1'b0;
    send(1, 40'h01_00000000, 0, 1, 0, 0, 0, "R1");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_plain();
    t_imm16();
    t_bits();
    t_pages();
    t_illegal();
    t_gaps();
    t_reset_mid();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule